// File: doc/BRIEF.md
# Cascaded Regulator Enable Sequencer

This block brings up a set of power rails one at a time after a wake request. The first rail is enabled one clock after wake is seen high. Each later rail is enabled only after the rail before it reports that its output is close to its final value. No fixed timer sits between stages, so a rail that ramps slowly pushes back every rail after it by exactly the extra time it takes.

After the last rail reports that it is in range, a settle counter runs for a set number of clock ticks. When the count completes, the power-good line is released. That line is modelled as the enable of an open-drain pull-down: a 1 pulls the line low, and a 0 lets it float high. A status bit reports the completed sequence at the same moment.

Dropping wake at any time turns every rail off and pulls power-good low in the same cycle. It also clears all sequencing progress.

Top module: `rail_enable_sequencer`

## Requirements
- R1: While `wake` is low, `rail_en` is all zeros, `pg_pull_low` is 1 and `seq_done` is 0, in the same cycle that `wake` is low (no clock edge needed).
- R2: Bit 0 of `rail_en` is the first rail. It becomes 1 one clock edge after `wake` is sampled high.
- R3: `rail_en[1]` becomes 1 one clock edge after an edge at which `rail_en[0]` and `in_range[0]` are both 1. It then stays 1 while `wake` stays high.
- R4: `rail_en[2]` becomes 1 one clock edge after an edge at which `rail_en[1]` and `in_range[1]` are both 1. It then stays 1 while `wake` stays high.
- R5: An `in_range` bit whose own rail is disabled has no effect. A stale flag does not advance the chain or the settle count, and rails are never enabled out of order (`rail_en[i]` implies `rail_en[i-1]`).
- R6: Power-good is released (`pg_pull_low` = 0, `seq_done` = 1) right after the SETTLE_TICKS-th consecutive clock edge at which `wake`, `rail_en[2]` and `in_range[2]` are all 1.
- R7: If `in_range[2]` drops before the settle count completes, the count restarts from zero. A full SETTLE_TICKS run is then needed again.
- R8: Once released, power-good stays released while `wake` stays high, even if `in_range[2]` later drops.
- R9: A wake drop clears all rail state and settle progress. The next wake needs the whole chain and a full settle count again.
- R10: Stage spacing follows only the flags. Holding `in_range[0]` low for any number of cycles delays `rail_en[1]`, `rail_en[2]` and the release by that same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake | input | 1 | Power-up request; low turns everything off |
| in_range | input | NUM_RAILS | Per-rail near-regulation flag, synchronous |
| rail_en | output | NUM_RAILS | Per-rail enable, bit 0 first |
| pg_pull_low | output | 1 | 1 = pull power-good low, 0 = release (float high) |
| seq_done | output | 1 | Sequence complete and power-good released |

## Verification
The assertions assume that `in_range` is already synchronous to `clk` and changes only between edges. They also assume that `wake` can fall at any cycle, and that a flag may be high while its rail is off. The directed stimulus changes every input on the falling clock edge and samples outputs there too. It raises flags on disabled rails on purpose, and drops `wake` and `in_range[2]` partway through settling, so that each of these assumptions is exercised.

// File: rtl/rail_seq_pkg.sv
// Package: shared helpers for the rail sequencer.
// Assumes: tick counts are positive.
package rail_seq_pkg;
    // Width of a counter able to hold 0..ticks-1 (at least one bit).
    function automatic int cnt_width(input int ticks);
        return (ticks < 2) ? 1 : $clog2(ticks);
    endfunction
endpackage

// File: rtl/rail_enable_chain.sv
// Module: rail_enable_chain
// Holds one enable flop per rail. Rail 0 follows wake one edge late.
// Rail i latches on once rail i-1 is enabled and reports in range.
// Assumes: in_range is synchronous to clk. Wake low clears every stage.
module rail_enable_chain #(
    parameter int NUM_RAILS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wake,
    input  logic [NUM_RAILS-1:0] in_range,
    output logic [NUM_RAILS-1:0] stage_q
);
    // First stage: register the wake request.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= wake;
    end

    for (genvar i = 1; i < NUM_RAILS; i++) begin : g_stage
        // Later stage: set by the previous enabled and in-range rail, held while awake.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= 1'b0;
            else        stage_q[i] <= wake && (stage_q[i] || (stage_q[i-1] && in_range[i-1]));
        end
    end
endmodule

// File: rtl/settle_timer.sv
// Module: settle_timer
// Counts consecutive edges with arm high and sets released after TICKS of them.
// A low arm before then restarts the count. Wake low clears everything.
// Assumes: TICKS >= 1.
module settle_timer
    import rail_seq_pkg::*;
#(
    parameter int TICKS = 28_750_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic arm,
    output logic released_q
);
    localparam int CW = cnt_width(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Settle count: advance while armed, restart on a gap, stop once released.
    always_ff @(posedge clk) begin
        if (!rst_n || !wake) begin
            cnt_q      <= '0;
            released_q <= 1'b0;
        end else if (!released_q) begin
            if (!arm) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                released_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rail_enable_sequencer.sv
// Module: rail_enable_sequencer (top)
// Enables rails in order, each gated by the previous rail's in-range flag.
// Releases the open-drain power-good line after a settle delay on the last rail.
// Assumes: in_range is synchronous. wake may drop at any cycle and gates the outputs at once.
module rail_enable_sequencer #(
    parameter int NUM_RAILS    = 3,
    parameter int SETTLE_TICKS = 28_750_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wake,
    input  logic [NUM_RAILS-1:0] in_range,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 pg_pull_low,
    output logic                 seq_done
);
    localparam int LAST = NUM_RAILS - 1;

    logic [NUM_RAILS-1:0] stage_q;
    logic                 released_q;
    logic                 last_armed;

    rail_enable_chain #(.NUM_RAILS(NUM_RAILS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake     (wake),
        .in_range (in_range),
        .stage_q  (stage_q)
    );

    // Settle arm: last rail enabled and its flag valid.
    always_comb last_armed = stage_q[LAST] && in_range[LAST];

    settle_timer #(.TICKS(SETTLE_TICKS)) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake       (wake),
        .arm        (last_armed),
        .released_q (released_q)
    );

    // Output gating: wake low forces rails off and power-good low immediately.
    always_comb begin
        rail_en     = wake ? stage_q : '0;
        seq_done    = wake && released_q;
        pg_pull_low = !seq_done;
    end
endmodule

// File: rtl/rail_seq_chk.sv
// Module: rail_seq_chk
// Checker for rail_enable_sequencer. It watches ports only and is attached with bind.
module rail_seq_chk #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wake,
    input logic [NUM_RAILS-1:0] in_range,
    input logic [NUM_RAILS-1:0] rail_en,
    input logic                 pg_pull_low,
    input logic                 seq_done
);
    localparam int LAST = NUM_RAILS - 1;

    // R1
    off_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |-> (rail_en == '0) && pg_pull_low && !seq_done);

    // R2
    first_rail_follows_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && $past(wake) && $past(rst_n)) |-> rail_en[0]);

    // R3
    second_rail_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[1]) |-> $past(rail_en[0] && in_range[0]));

    // R5
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rail_en >> 1) & ~rail_en) == '0);

    // R6
    release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_pull_low) |-> $past(rail_en[LAST] && in_range[LAST]));

    // R8
    release_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_pull_low && wake) |=> (!wake || !pg_pull_low));
endmodule

bind rail_enable_sequencer rail_seq_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake        (wake),
    .in_range    (in_range),
    .rail_en     (rail_en),
    .pg_pull_low (pg_pull_low),
    .seq_done    (seq_done)
);

// File: tb/rail_enable_sequencer_test.sv
module rail_enable_sequencer_test;
    localparam int NR = 3;
    localparam int ST = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wake = 1'b0;
    logic [NR-1:0] in_range = '0;
    logic [NR-1:0] rail_en;
    logic          pg_pull_low;
    logic          seq_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    rail_enable_sequencer #(.NUM_RAILS(NR), .SETTLE_TICKS(ST)) uut (
        .clk(clk), .rst_n(rst_n), .wake(wake), .in_range(in_range),
        .rail_en(rail_en), .pg_pull_low(pg_pull_low), .seq_done(seq_done)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Packs the outputs as {pg_pull_low, seq_done, rail_en}.
    function automatic logic [7:0] outs();
        return {3'b0, pg_pull_low, seq_done, rail_en};
    endfunction

    task automatic go_sleep();
        wake = 1'b0; in_range = '0; step(2);
    endtask

    // Wakes up and walks the chain to the point where rail 2 is enabled.
    task automatic bring_to_last();
        wake = 1'b1; step(1);
        in_range[0] = 1'b1; step(1);
        in_range[1] = 1'b1; step(1);
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 reset", outs(), {3'b0, 1'b1, 1'b0, 3'b000});
        rst_n = 1'b1; step(2);
        chk("R1 asleep", outs(), {3'b0, 1'b1, 1'b0, 3'b000});
    endtask

    task automatic t_basic();
        wake = 1'b1; step(1);
        chk("R2 first rail", outs(), {3'b0, 1'b1, 1'b0, 3'b001});
        step(3);
        chk("R3 waits for flag", outs(), {3'b0, 1'b1, 1'b0, 3'b001});
        in_range[0] = 1'b1; step(1);
        chk("R3 second rail", {5'b0, rail_en}, 8'h03);
        in_range[1] = 1'b1; step(1);
        chk("R4 third rail", {5'b0, rail_en}, 8'h07);
        in_range[2] = 1'b1; step(ST - 1);
        chk("R6 not yet", {7'b0, pg_pull_low}, 8'h1);
        step(1);
        chk("R6 released", {6'b0, pg_pull_low, seq_done}, 8'h01);
        in_range[2] = 1'b0; step(3);
        chk("R8 held", {6'b0, pg_pull_low, seq_done}, 8'h01);
        wake = 1'b0; #1;
        chk("R1 immediate off", outs(), {3'b0, 1'b1, 1'b0, 3'b000});
        go_sleep();
    endtask

    task automatic t_stale();
        in_range = 3'b111; wake = 1'b1; step(1);
        chk("R5 stale flags ignored", {5'b0, rail_en}, 8'h01);
        step(1);
        chk("R5 chain one per edge", {5'b0, rail_en}, 8'h03);
        step(1);
        chk("R5 chain third", {5'b0, rail_en}, 8'h07);
        step(ST - 1);
        chk("R5 settle not early", {7'b0, pg_pull_low}, 8'h1);
        step(1);
        chk("R5 settle exact", {7'b0, pg_pull_low}, 8'h0);
        go_sleep();
    endtask

    task automatic t_restart();
        bring_to_last();
        in_range[2] = 1'b1; step(ST - 2);
        in_range[2] = 1'b0; step(1);
        in_range[2] = 1'b1; step(ST - 1);
        chk("R7 restarted", {7'b0, pg_pull_low}, 8'h1);
        step(1);
        chk("R7 full count", {6'b0, pg_pull_low, seq_done}, 8'h01);
        go_sleep();
    endtask

    task automatic t_wake_drop();
        bring_to_last();
        in_range[2] = 1'b1; step(ST - 3);
        wake = 1'b0; step(1);
        chk("R9 cleared", outs(), {3'b0, 1'b1, 1'b0, 3'b000});
        wake = 1'b1; step(1);
        chk("R9 chain from start", {5'b0, rail_en}, 8'h01);
        step(2);
        chk("R9 chain rebuilt", {5'b0, rail_en}, 8'h07);
        step(ST - 1);
        chk("R9 full settle again", {7'b0, pg_pull_low}, 8'h1);
        step(1);
        chk("R9 released", {7'b0, pg_pull_low}, 8'h0);
        go_sleep();
    endtask

    task automatic t_slow_ramp();
        wake = 1'b1; step(1);
        step(10);
        chk("R10 delayed rail 1", {5'b0, rail_en}, 8'h01);
        in_range[0] = 1'b1; step(1);
        chk("R10 rail 1 after flag", {5'b0, rail_en}, 8'h03);
        step(7);
        chk("R10 delayed rail 2", {5'b0, rail_en}, 8'h03);
        in_range[1] = 1'b1; in_range[2] = 1'b1; step(1);
        chk("R10 rail 2 after flag", {5'b0, rail_en}, 8'h07);
        step(ST - 1);
        chk("R10 release pending", {7'b0, pg_pull_low}, 8'h1);
        step(1);
        chk("R10 release", {7'b0, seq_done}, 8'h1);
        go_sleep();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_stale();
        t_restart();
        t_wake_drop();
        t_slow_ramp();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule